// File: doc/BRIEF.md
# Misaligned Load/Store Access Splitter

This block sits between a load/store unit and a 64-bit data cache port. It accepts one memory request at a time: a byte address, an operand size (1, 2, 4 or 8 bytes), a floating-point flag, a multiword flag and a load/store direction. It decides whether the request may run at all. If it may, it issues one or two cache-port beats with per-lane byte enables. For a load it merges the returned lanes into a single right-justified big-endian operand.

Integer operands that straddle a 64-bit line boundary are split in hardware into exactly two beats. Floating-point and multiword requests follow stricter rules. An address that is not a multiple of four raises a fault and produces no cache traffic. A floating-point double word that sits on a word boundary, but not on a double-word boundary, costs two beats.

The requester sees one completion pulse with the merged data, or one fault pulse. A multiword request moves one word per request; stepping through the sequence of words is left to the requester.

Top module: `lsu_align_splitter`

## Requirements
- R1: A request whose address is a multiple of its operand length (size code 0/1/2/3 = 1/2/4/8 bytes) completes with exactly one cache beat.
- R2: Every cache beat presents an address with its three low bits zero. The first beat carries the line that holds the request address, and a second beat carries the next line (first line plus 8).
- R3: An integer request whose bytes stay within one 8-byte line uses one beat, even when misaligned. One whose bytes run past the line end uses exactly two beats.
- R4: Byte lanes are big-endian. Enable bit i, and data bits [8i+7:8i], belong to the byte at line offset 7-i, so the lowest address uses the most significant lane.
- R5: Load data is returned right-justified. The byte at the request address is the most significant byte of the operand, and all bits above the operand are zero.
- R6: A floating-point request whose address has either of its two low bits set gives a one-cycle fault pulse and issues no cache beat.
- R7: A floating-point 8-byte request at line offset 4 completes as two 4-byte beats. At line offset 0 it takes one beat.
- R8: A multiword request moves one 4-byte word, whatever the size field holds. It faults with no cache beat unless its address is a multiple of four.
- R9: A store writes exactly the operand's bytes across its beats. No other byte of memory changes.
- R10: Each accepted request yields exactly one completion pulse or one fault pulse, never both. A new request is accepted only while no access is in progress.
- R11: While a beat is offered and the cache holds ready low, the beat's valid, address, enables and data stay unchanged.
- R12: After reset the block is idle and ready. It shows no cache beat, no completion and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the operand's lowest byte |
| req_size | input | 2 | Operand size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_fp | input | 1 | Floating-point access |
| req_multi | input | 1 | Multiword access (one word per request) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store operand, right-justified |
| cp_valid | output | 1 | Cache beat offered |
| cp_ready | input | 1 | Cache accepts the beat |
| cp_addr | output | ADDR_W | Line address of the beat |
| cp_store | output | 1 | Beat is a write |
| cp_be | output | 8 | Byte enables, bit i covers data bits [8i+7:8i] |
| cp_wdata | output | 64 | Write data in lane position |
| cp_rvalid | input | 1 | Cache finished the accepted beat |
| cp_rdata | input | 64 | Line data returned for the beat |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | One-cycle alignment fault pulse |
| rsp_data | output | 64 | Merged load operand, valid with rsp_valid |

## Verification
The assertions assume a well-behaved cache port. It raises cp_rvalid exactly once for each accepted beat, never before the acceptance, and keeps at most one beat outstanding. The bench's cache model follows this rule: it answers on the cycle after each accepted beat, and it lowers cp_ready only while a beat is being offered. The bench offers a request only after the previous response has been seen, so the block is always idle when a request arrives. Addresses stay inside the model's 64-byte memory window.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;
    localparam int LANES = 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int DW    = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } op_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic             fault;
        logic             two_beat;
        logic [LANES-1:0] be_first;
        logic [LANES-1:0] be_second;
    } beat_plan_t;

    function automatic logic [OFF_W:0] op_bytes(input op_size_e s);
        return (OFF_W+1)'(1) << s;
    endfunction
endpackage

// File: rtl/lsa_classify.sv
`timescale 1ns/1ps
module lsa_classify
    import lsa_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  op_size_e         size,
    input  logic             fp,
    input  logic             multi,
    output beat_plan_t       plan
);
    logic [OFF_W:0]     nbytes;
    logic [2*LANES-1:0] mask;
    logic               word_mis;

    always_comb begin
        nbytes   = op_bytes(size);
        word_mis = |off[1:0];
        // operand bytes occupy a 16-lane window starting at the line offset
        mask     = '1;
        mask     = mask << (2*LANES - int'(nbytes));
        mask     = mask >> off;
        plan.fault     = word_mis && (fp || multi);
        plan.be_first  = mask[2*LANES-1:LANES];
        plan.be_second = mask[LANES-1:0];
        plan.two_beat  = (|mask[LANES-1:0]) && !plan.fault;
    end
endmodule

// File: rtl/lsa_store_steer.sv
`timescale 1ns/1ps
module lsa_store_steer
    import lsa_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W:0]   nbytes,
    input  logic [DW-1:0]    operand,
    output logic [DW-1:0]    beat_first,
    output logic [DW-1:0]    beat_second
);
    logic [2*DW-1:0] win;

    always_comb begin
        win = {operand, {DW{1'b0}}};
        win = win << (8 * (LANES - int'(nbytes)));
        win = win >> (8 * int'(off));
        beat_first  = win[2*DW-1:DW];
        beat_second = win[DW-1:0];
    end
endmodule

// File: rtl/lsa_load_merge.sv
`timescale 1ns/1ps
module lsa_load_merge
    import lsa_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W:0]   nbytes,
    input  logic [DW-1:0]    line_first,
    input  logic [DW-1:0]    line_second,
    output logic [DW-1:0]    operand
);
    logic [2*DW-1:0] win;
    logic [DW-1:0]   top;

    always_comb begin
        win     = {line_first, line_second} << (8 * int'(off));
        top     = win[2*DW-1:DW];
        operand = top >> (8 * (LANES - int'(nbytes)));
    end
endmodule

// File: rtl/lsu_align_splitter.sv
`timescale 1ns/1ps
module lsu_align_splitter
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_fp,
    input  logic              req_multi,
    input  logic              req_store,
    input  logic [63:0]       req_wdata,
    output logic              cp_valid,
    input  logic              cp_ready,
    output logic [ADDR_W-1:0] cp_addr,
    output logic              cp_store,
    output logic [7:0]        cp_be,
    output logic [63:0]       cp_wdata,
    input  logic              cp_rvalid,
    input  logic [63:0]       cp_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [63:0]       rsp_data
);
    localparam int LINE_W = ADDR_W - OFF_W;

    seq_state_e        state;
    beat_plan_t        cls_plan, plan_q;
    op_size_e          eff_size;
    logic [OFF_W:0]    eff_bytes, nbytes_q;
    logic [OFF_W-1:0]  off_q;
    logic [LINE_W-1:0] line_q;
    logic              store_q, second_q;
    logic [DW-1:0]     st_first, st_second, wbeat0_q, wbeat1_q;
    logic [DW-1:0]     rd0_q, rd1_q, merged;
    logic              accept;

    assign eff_size  = req_multi ? SZ_WORD : op_size_e'(req_size);
    assign eff_bytes = op_bytes(eff_size);
    assign accept    = req_valid && req_ready;

    lsa_classify u_classify (
        .off   (req_addr[OFF_W-1:0]),
        .size  (eff_size),
        .fp    (req_fp),
        .multi (req_multi),
        .plan  (cls_plan)
    );

    lsa_store_steer u_steer (
        .off         (req_addr[OFF_W-1:0]),
        .nbytes      (eff_bytes),
        .operand     (req_wdata),
        .beat_first  (st_first),
        .beat_second (st_second)
    );

    lsa_load_merge u_merge (
        .off         (off_q),
        .nbytes      (nbytes_q),
        .line_first  (rd0_q),
        .line_second (rd1_q),
        .operand     (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            plan_q   <= '0;
            nbytes_q <= '0;
            off_q    <= '0;
            line_q   <= '0;
            store_q  <= 1'b0;
            second_q <= 1'b0;
            wbeat0_q <= '0;
            wbeat1_q <= '0;
            rd0_q    <= '0;
            rd1_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    plan_q   <= cls_plan;
                    nbytes_q <= eff_bytes;
                    off_q    <= req_addr[OFF_W-1:0];
                    line_q   <= req_addr[ADDR_W-1:OFF_W];
                    store_q  <= req_store;
                    second_q <= 1'b0;
                    wbeat0_q <= st_first;
                    wbeat1_q <= st_second;
                    rd0_q    <= '0;
                    rd1_q    <= '0;
                    state    <= cls_plan.fault ? ST_FAULT : ST_ISSUE;
                end
                ST_ISSUE: if (cp_ready) state <= ST_WAIT;
                ST_WAIT: if (cp_rvalid) begin
                    if (!second_q) begin
                        rd0_q <= cp_rdata;
                        if (plan_q.two_beat) begin
                            second_q <= 1'b1;
                            state    <= ST_ISSUE;
                        end else begin
                            state <= ST_DONE;
                        end
                    end else begin
                        rd1_q <= cp_rdata;
                        state <= ST_DONE;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        cp_valid  = (state == ST_ISSUE);
        cp_addr   = {line_q + LINE_W'(second_q), {OFF_W{1'b0}}};
        cp_store  = store_q;
        cp_be     = second_q ? plan_q.be_second : plan_q.be_first;
        cp_wdata  = second_q ? wbeat1_q : wbeat0_q;
        rsp_valid = (state == ST_DONE);
        rsp_fault = (state == ST_FAULT);
        rsp_data  = (rsp_valid && !store_q) ? merged : '0;
    end

    a_r2_line_address: assert property (@(posedge clk) disable iff (rst)
        cp_valid |-> (cp_addr[OFF_W-1:0] == '0));

    a_r3_integer_crossing: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_fp && !req_multi &&
         ((int'(req_addr[OFF_W-1:0]) + int'(eff_bytes)) > LANES))
        |-> cls_plan.two_beat);

    a_r6_fp_fault: assert property (@(posedge clk) disable iff (rst)
        (accept && req_fp && (|req_addr[1:0])) |=> (rsp_fault && !cp_valid));

    a_r7_fp_double_split: assert property (@(posedge clk) disable iff (rst)
        (accept && req_fp && !req_multi && eff_size == SZ_DWORD &&
         req_addr[OFF_W-1:0] == 3'd4) |-> (cls_plan.two_beat && !cls_plan.fault));

    a_r8_multi_fault: assert property (@(posedge clk) disable iff (rst)
        (accept && req_multi && (|req_addr[1:0])) |=> rsp_fault);

    a_r9_lane_count: assert property (@(posedge clk) disable iff (rst)
        (accept && !cls_plan.fault) |->
        ($countones({cls_plan.be_first, cls_plan.be_second}) == int'(eff_bytes)));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_fault));

    a_r10_busy: assert property (@(posedge clk) disable iff (rst)
        cp_valid |-> !req_ready);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || rsp_fault) |=> (!rsp_valid && !rsp_fault && req_ready));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (cp_valid && !cp_ready) |=>
        (cp_valid && $stable(cp_addr) && $stable(cp_be) && $stable(cp_wdata)));
endmodule

// File: tb/lsu_align_splitter_bench.sv
`timescale 1ns/1ps
module lsu_align_splitter_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_fp, req_multi, req_store;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata;
    logic        cp_valid, cp_ready, cp_store, cp_rvalid;
    logic [31:0] cp_addr;
    logic [7:0]  cp_be;
    logic [63:0] cp_wdata, cp_rdata;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0]  mem [0:63];
    int          beat_cnt = 0;
    logic [31:0] last_addr;
    logic        pend = 0;
    logic [63:0] pend_data;
    bit          stall_en = 0;
    int          hold_cnt = 0;

    logic [63:0] got_data;
    logic        got_fault;
    int          got_beats;

    always #2 clk = ~clk;

    lsu_align_splitter u_lsu_align_splitter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_fp(req_fp), .req_multi(req_multi),
        .req_store(req_store), .req_wdata(req_wdata),
        .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_addr(cp_addr),
        .cp_store(cp_store), .cp_be(cp_be), .cp_wdata(cp_wdata),
        .cp_rvalid(cp_rvalid), .cp_rdata(cp_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data)
    );

    // cache model: big-endian lanes, answers one cycle after acceptance
    always @(negedge clk) begin
        if (rst) begin
            cp_rvalid = 1'b0;
            cp_rdata  = '0;
            cp_ready  = 1'b1;
            pend      = 1'b0;
        end else begin
            cp_rvalid = pend;
            cp_rdata  = pend_data;
            pend      = 1'b0;
            if (cp_valid && stall_en && hold_cnt < 3) begin
                cp_ready = 1'b0;
                hold_cnt++;
            end else begin
                cp_ready = 1'b1;
            end
            if (cp_valid && cp_ready) begin
                beat_cnt++;
                last_addr = cp_addr;
                for (int i = 0; i < 8; i++) begin
                    if (cp_store && cp_be[i])
                        mem[(cp_addr[5:0] + 6'(7 - i))] = cp_wdata[8*i +: 8];
                end
                for (int i = 0; i < 8; i++)
                    pend_data[8*i +: 8] = mem[(cp_addr[5:0] + 6'(7 - i))];
                pend = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_load(input int a, input int n);
        logic [63:0] r = '0;
        for (int k = 0; k < n; k++) r = (r << 8) | 64'(mem[(a + k) & 63]);
        return r;
    endfunction

    function automatic int ref_beats(input int a, input int n);
        return ((a % 8) + n > 8) ? 2 : 1;
    endfunction

    task automatic run(input int a, input logic [1:0] sz, input logic fp,
                       input logic multi, input logic st, input logic [63:0] wd);
        int start;
        int waitc = 0;
        @(negedge clk); #1;
        start     = beat_cnt;
        req_valid = 1'b1;
        req_addr  = 32'(a);
        req_size  = sz;
        req_fp    = fp;
        req_multi = multi;
        req_store = st;
        req_wdata = wd;
        @(negedge clk); #1;
        req_valid = 1'b0;
        while (!(rsp_valid || rsp_fault) && waitc < 60) begin
            @(negedge clk); #1;
            waitc++;
        end
        got_data  = rsp_data;
        got_fault = rsp_fault;
        got_beats = beat_cnt - start;
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1, "R12 ready", 64'(req_ready), 64'd1);
        chk(cp_valid === 1'b0 && rsp_valid === 1'b0 && rsp_fault === 1'b0,
            "R12 quiet", {61'd0, cp_valid, rsp_valid, rsp_fault}, 64'd0);
    endtask

    task automatic t_aligned;
        int addrs [4] = '{5, 10, 20, 40};
        for (int s = 0; s < 4; s++) begin
            run(addrs[s], 2'(s), 1'b0, 1'b0, 1'b0, '0);
            chk(got_beats == 1, "R1 one beat", 64'(got_beats), 64'd1);
            chk(got_data == ref_load(addrs[s], 1 << s), "R5 aligned value",
                got_data, ref_load(addrs[s], 1 << s));
        end
    endtask

    task automatic t_inline_misaligned;
        run(11, 2'd1, 1'b0, 1'b0, 1'b0, '0);
        chk(got_beats == 1 && got_data == ref_load(11, 2), "R3 half in line",
            got_data, ref_load(11, 2));
        run(18, 2'd2, 1'b0, 1'b0, 1'b0, '0);
        chk(got_beats == 1 && got_data == ref_load(18, 4), "R3 word in line",
            got_data, ref_load(18, 4));
        run(31, 2'd0, 1'b0, 1'b0, 1'b0, '0);
        chk(got_beats == 1 && got_data == 64'(mem[31]), "R4 last lane byte",
            got_data, 64'(mem[31]));
    endtask

    task automatic t_crossing;
        run(14, 2'd2, 1'b0, 1'b0, 1'b0, '0);
        chk(got_beats == 2, "R3 word crossing beats", 64'(got_beats), 64'd2);
        chk(got_data == ref_load(14, 4), "R5 word crossing value",
            got_data, ref_load(14, 4));
        chk(last_addr == 32'd16, "R2 second line", 64'(last_addr), 64'd16);
        run(27, 2'd3, 1'b0, 1'b0, 1'b0, '0);
        chk(got_beats == ref_beats(27, 8) && got_data == ref_load(27, 8),
            "R4 dword crossing value", got_data, ref_load(27, 8));
        run(39, 2'd1, 1'b0, 1'b0, 1'b0, '0);
        chk(got_beats == 2 && got_data == ref_load(39, 2), "R3 half crossing",
            got_data, ref_load(39, 2));
        chk(last_addr == 32'd40, "R2 next line", 64'(last_addr), 64'd40);
    endtask

    task automatic t_fp_rules;
        run(18, 2'd2, 1'b1, 1'b0, 1'b0, '0);
        chk(got_fault && got_beats == 0, "R6 fp word fault",
            {got_fault, 63'(got_beats)}, {1'b1, 63'd0});
        run(33, 2'd3, 1'b1, 1'b0, 1'b0, '0);
        chk(got_fault && got_beats == 0, "R6 fp dword fault",
            {got_fault, 63'(got_beats)}, {1'b1, 63'd0});
        run(20, 2'd3, 1'b1, 1'b0, 1'b0, '0);
        chk(!got_fault && got_beats == 2, "R7 fp dword offset four beats",
            64'(got_beats), 64'd2);
        chk(got_data == ref_load(20, 8), "R7 fp dword value",
            got_data, ref_load(20, 8));
        run(24, 2'd3, 1'b1, 1'b0, 1'b0, '0);
        chk(!got_fault && got_beats == 1, "R7 fp dword aligned one beat",
            64'(got_beats), 64'd1);
    endtask

    task automatic t_multi;
        run(9, 2'd0, 1'b0, 1'b1, 1'b0, '0);
        chk(got_fault && got_beats == 0, "R8 multi fault",
            {got_fault, 63'(got_beats)}, {1'b1, 63'd0});
        run(36, 2'd0, 1'b0, 1'b1, 1'b0, '0);
        chk(!got_fault && got_beats == 1 && got_data == ref_load(36, 4),
            "R8 multi word", got_data, ref_load(36, 4));
    endtask

    task automatic t_store_split;
        logic [7:0] before_b, after_b;
        before_b = mem[44];
        after_b  = mem[53];
        run(45, 2'd3, 1'b0, 1'b0, 1'b1, 64'h0102_0304_0506_0708);
        chk(got_beats == 2 && !got_fault, "R9 store beats", 64'(got_beats), 64'd2);
        chk(ref_load(45, 8) == 64'h0102_0304_0506_0708, "R9 store bytes",
            ref_load(45, 8), 64'h0102_0304_0506_0708);
        chk(mem[44] == before_b && mem[53] == after_b, "R9 neighbours kept",
            {48'd0, mem[44], mem[53]}, {48'd0, before_b, after_b});
        run(45, 2'd3, 1'b0, 1'b0, 1'b0, '0);
        chk(got_data == 64'h0102_0304_0506_0708, "R9 store readback",
            got_data, 64'h0102_0304_0506_0708);
        run(2, 2'd1, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_ABCD);
        chk(mem[2] == 8'hAB && mem[3] == 8'hCD, "R4 store lane order",
            {48'd0, mem[2], mem[3]}, 64'hABCD);
    endtask

    task automatic t_stall;
        hold_cnt = 0;
        stall_en = 1;
        run(30, 2'd2, 1'b0, 1'b0, 1'b0, '0);
        stall_en = 0;
        chk(got_beats == 2 && got_data == ref_load(30, 4), "R11 stalled beat",
            got_data, ref_load(30, 4));
        chk(!got_fault, "R10 single completion", 64'(got_fault), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
        rst       = 1'b1;
        req_valid = 1'b0;
        req_addr  = '0;
        req_size  = '0;
        req_fp    = 1'b0;
        req_multi = 1'b0;
        req_store = 1'b0;
        req_wdata = '0;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        t_reset();
        t_aligned();
        t_inline_misaligned();
        t_crossing();
        t_fp_rules();
        t_multi();
        t_store_split();
        t_stall();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule